// File: doc/BRIEF.md
# Interrupt Message Destination Filter

This block takes in interrupt messages and decides two things for each one: which of the two processor buses must carry it, and which of up to eight local agents claim it. Every message has an 8-bit destination ID, a destination mode (physical or flat logical), a delivery kind (directed, redirectable or broadcast) and a source tag (I/O, bus 0 or bus 1). Each agent's 8-bit physical ID comes in on a port. Each agent's 8-bit logical ID lives in a register that is written through a small register port.

In physical mode an agent claims a message when the destination ID equals its physical ID. In flat logical mode an agent claims it when the destination ID and the agent's logical ID share at least one set bit. The destination value 8'hFF claims every agent in both modes, and so does a message of the broadcast kind. The bus fan-out depends on the source and the kind. A directed message from I/O goes to both buses. A directed message from one processor bus goes only to the other bus. A redirectable message has already had its target chosen upstream, so it goes to both buses.

Messages enter through a valid/ready handshake, and the registered result appears one cycle after acceptance. A sticky status bit records any message that no agent claimed.

Top module: `irq_dest_filter`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1, every logical ID register reads 0 and the status register reads 0.
- R2: In physical mode (in_mode=0), agent i claims (out_claim[i]=1) when in_dest_id equals agent_phys_id[8*i+7:8*i].
- R3: A destination ID of 8'hFF sets every out_claim bit, in physical mode and in logical mode alike.
- R4: In logical mode (in_mode=1), agent i claims when in_dest_id AND its logical ID is nonzero. More than one agent may claim.
- R5: A message of the broadcast kind (in_kind=2) sets every out_claim bit, whatever its destination ID.
- R6: A directed message (in_kind=0) or a broadcast message (in_kind=2) whose source is I/O (in_src=0) gives out_bus_en=2'b11. Bit 0 is bus 0 and bit 1 is bus 1.
- R7: A directed or broadcast message whose source is bus 0 (in_src=1) gives out_bus_en=2'b10. One whose source is bus 1 (in_src=2) gives out_bus_en=2'b01.
- R8: A redirectable message (in_kind=1) gives out_bus_en=2'b11 from any source.
- R9: A message is accepted on a clock edge where in_valid and in_ready are both 1. Its result appears with out_valid=1 after that edge. in_ready = !out_valid || out_ready. While out_ready is 0, out_valid, out_claim and out_bus_en hold their values.
- R10: An accepted message that no agent claims sets status bit 0. The bit stays set until a write to the status address (NUM_AGENTS) with data bit 0 equal to 1. When a set and a clear fall in the same cycle, the set wins.
- R11: A logical ID write at register address i (i < NUM_AGENTS) that lands on the same edge as a message acceptance affects only later messages.
- R12: Status bit 1 is the logical-mode format bit. It always reads 0 (flat), and writes cannot change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Block can accept a message |
| in_dest_id | input | 8 | Destination ID of the message |
| in_mode | input | 1 | 0 physical, 1 flat logical |
| in_kind | input | 2 | 0 directed, 1 redirectable, 2 broadcast |
| in_src | input | 2 | 0 I/O, 1 bus 0, 2 bus 1 |
| agent_phys_id | input | 8*NUM_AGENTS | Physical ID of each agent, agent i at bits 8i+7:8i |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | $clog2(NUM_AGENTS+1) | Write address: logical ID i at i, status at NUM_AGENTS |
| reg_wr_data | input | 8 | Write data |
| reg_rd_addr | input | $clog2(NUM_AGENTS+1) | Read address |
| reg_rd_data | output | 8 | Read data (combinational) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_bus_en | output | 2 | Buses that must carry the message |
| out_claim | output | NUM_AGENTS | Agents that claim the message |

## Verification
On every cycle the assertions check the broadcast-claims-all rule for the all-ones ID, the both-bus fan-out of redirectable messages, that a processor-sourced directed message is never sent back to its own bus, that results hold under backpressure, and how the no-target bit is set and kept. The match arithmetic itself needs the bench's scenarios: physical equality, overlapping flat logical IDs that claim several agents, and the broadcast kind with an arbitrary ID. So do the ordering of a register write against a message on the same edge, the write-one-to-clear path and the read-only format bit.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;

    typedef enum logic {
        DM_PHYS  = 1'b0,
        DM_LOGIC = 1'b1
    } dmode_e;

    typedef enum logic [1:0] {
        DLV_DIRECTED = 2'd0,
        DLV_REDIRECT = 2'd1,
        DLV_BCAST    = 2'd2,
        DLV_RSVD     = 2'd3
    } dlv_e;

    typedef enum logic [1:0] {
        SRC_IO   = 2'd0,
        SRC_BUS0 = 2'd1,
        SRC_BUS1 = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    localparam logic [7:0] ID_ALL = 8'hFF;

    typedef struct packed {
        logic [7:0] id;
        dmode_e     mode;
        dlv_e       kind;
        src_e       src;
    } irq_msg_t;

    // bit 0 = bus 0, bit 1 = bus 1
    function automatic logic [1:0] route_buses(dlv_e kind, src_e src);
        logic [1:0] r;
        if (kind == DLV_REDIRECT) begin
            r = 2'b11;
        end else begin
            case (src)
                SRC_BUS0: r = 2'b10;
                SRC_BUS1: r = 2'b01;
                default:  r = 2'b11;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ldr_regs.sv
module irq_ldr_regs
    import irq_filt_pkg::*;
#(
    parameter int NUM_AGENTS = 8,
    parameter int AW = $clog2(NUM_AGENTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic [AW-1:0]               rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        nt_set,
    output logic [NUM_AGENTS-1:0][7:0]  ldr
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_AGENTS);
    localparam logic          FMT_FLAT  = 1'b0;

    logic nt_q;
    logic nt_clr;

    assign nt_clr = wr_en && (wr_addr == STAT_ADDR) && wr_data[0];

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_ldr
        always_ff @(posedge clk) begin
            if (rst) begin
                ldr[i] <= '0;
            end else if (wr_en && (wr_addr == AW'(i))) begin
                ldr[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nt_q <= 1'b0;
        end else if (nt_set) begin
            nt_q <= 1'b1;
        end else if (nt_clr) begin
            nt_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_AGENTS; i++) begin
            if (rd_addr == AW'(i)) rd_data = ldr[i];
        end
        if (rd_addr == STAT_ADDR) rd_data = {6'b0, FMT_FLAT, nt_q};
    end

    // R10: the no-target bit stays set unless it is cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        nt_q && !nt_clr |=> nt_q);

    // R10: a set request always lands
    a_r10_set_lands: assert property (@(posedge clk) disable iff (rst)
        nt_set |=> nt_q);

endmodule

// File: rtl/irq_claim_match.sv
module irq_claim_match
    import irq_filt_pkg::*;
#(
    parameter int NUM_AGENTS = 8
) (
    input  irq_msg_t                    msg,
    input  logic [NUM_AGENTS*8-1:0]     phys_ids,
    input  logic [NUM_AGENTS-1:0][7:0]  ldr,
    output logic [NUM_AGENTS-1:0]       claim
);
    logic every;

    assign every = (msg.id == ID_ALL) || (msg.kind == DLV_BCAST);

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        logic phys_hit;
        logic log_hit;
        assign phys_hit = (msg.id == phys_ids[8*i +: 8]);
        assign log_hit  = |(msg.id & ldr[i]);
        assign claim[i] = every || ((msg.mode == DM_PHYS) ? phys_hit : log_hit);
    end

endmodule

// File: rtl/irq_bus_route.sv
module irq_bus_route
    import irq_filt_pkg::*;
(
    input  irq_msg_t    msg,
    output logic [1:0]  bus_en
);
    assign bus_en = route_buses(msg.kind, msg.src);
endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter
    import irq_filt_pkg::*;
#(
    parameter int NUM_AGENTS = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [7:0]                          in_dest_id,
    input  logic                                in_mode,
    input  logic [1:0]                          in_kind,
    input  logic [1:0]                          in_src,
    input  logic [NUM_AGENTS*8-1:0]             agent_phys_id,
    input  logic                                reg_wr_en,
    input  logic [$clog2(NUM_AGENTS+1)-1:0]     reg_wr_addr,
    input  logic [7:0]                          reg_wr_data,
    input  logic [$clog2(NUM_AGENTS+1)-1:0]     reg_rd_addr,
    output logic [7:0]                          reg_rd_data,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [1:0]                          out_bus_en,
    output logic [NUM_AGENTS-1:0]               out_claim
);
    localparam int AW = $clog2(NUM_AGENTS + 1);

    irq_msg_t                   msg_c;
    irq_msg_t                   msg_q;
    logic [NUM_AGENTS-1:0][7:0] ldr;
    logic [NUM_AGENTS-1:0]      claim_c;
    logic [1:0]                 bus_c;
    logic                       accept;
    logic                       nt_set;

    assign msg_c.id   = in_dest_id;
    assign msg_c.mode = dmode_e'(in_mode);
    assign msg_c.kind = dlv_e'(in_kind);
    assign msg_c.src  = src_e'(in_src);

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign nt_set   = accept && (claim_c == '0);

    irq_ldr_regs #(.NUM_AGENTS(NUM_AGENTS), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .nt_set  (nt_set),
        .ldr     (ldr)
    );

    irq_claim_match #(.NUM_AGENTS(NUM_AGENTS)) u_match (
        .msg      (msg_c),
        .phys_ids (agent_phys_id),
        .ldr      (ldr),
        .claim    (claim_c)
    );

    irq_bus_route u_route (
        .msg    (msg_c),
        .bus_en (bus_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_claim  <= '0;
            out_bus_en <= '0;
            msg_q      <= '0;
        end else if (accept) begin
            out_valid  <= 1'b1;
            out_claim  <= claim_c;
            out_bus_en <= bus_c;
            msg_q      <= msg_c;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // R1: reset empties the output stage
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R3: an all-ones destination claims every agent
    a_r3_all_ones: assert property (@(posedge clk) disable iff (rst)
        out_valid && (msg_q.id == ID_ALL) |-> (&out_claim));

    // R8: redirectable messages go to both buses
    a_r8_redirect_both: assert property (@(posedge clk) disable iff (rst)
        out_valid && (msg_q.kind == DLV_REDIRECT) |-> (out_bus_en == 2'b11));

    // R7: a directed message never returns to its own bus
    a_r7_not_origin: assert property (@(posedge clk) disable iff (rst)
        out_valid && (msg_q.kind == DLV_DIRECTED) && (msg_q.src == SRC_BUS0)
        |-> !out_bus_en[0]);

    // R9: held result under backpressure
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_claim) && $stable(out_bus_en));

    // R9: a message is taken only when ready
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (rst)
        in_valid && out_valid && !out_ready |=> $stable(out_claim));

endmodule

// File: tb/test_irq_dest_filter.sv
module test_irq_dest_filter;
    localparam int N  = 8;
    localparam int AW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_dest_id = '0;
    logic in_mode = 1'b0;
    logic [1:0] in_kind = '0;
    logic [1:0] in_src = '0;
    logic [N*8-1:0] agent_phys_id;
    logic reg_wr_en = 1'b0;
    logic [AW-1:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic [AW-1:0] reg_rd_addr = '0;
    logic [7:0] reg_rd_data;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [1:0] out_bus_en;
    logic [N-1:0] out_claim;

    int checks = 0;
    int failures = 0;

    logic [7:0] ldr_m [N];
    logic [7:0] phys_m [N];
    logic [N+1:0] expq [$];   // {bus_en, claim}
    string tagq [$];

    always #5 clk = ~clk;

    irq_dest_filter #(.NUM_AGENTS(N)) i_irq_dest_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest_id(in_dest_id), .in_mode(in_mode), .in_kind(in_kind), .in_src(in_src),
        .agent_phys_id(agent_phys_id), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_bus_en(out_bus_en),
        .out_claim(out_claim)
    );

    for (genvar g = 0; g < N; g++) begin : g_phys
        assign phys_m[g] = 8'h20 + 8'(g * 3);
        assign agent_phys_id[8*g +: 8] = phys_m[g];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N+1:0] model(logic [7:0] id, bit mode, logic [1:0] kind, logic [1:0] src);
        logic [N-1:0] c;
        logic [1:0] b;
        for (int i = 0; i < N; i++) begin
            if (id == 8'hFF || kind == 2'd2) c[i] = 1'b1;
            else if (!mode) c[i] = (id == phys_m[i]);
            else c[i] = |(id & ldr_m[i]);
        end
        if (kind == 2'd1) b = 2'b11;
        else if (src == 2'd1) b = 2'b10;
        else if (src == 2'd2) b = 2'b01;
        else b = 2'b11;
        return {b, c};
    endfunction

    task automatic send(input logic [7:0] id, input bit mode, input logic [1:0] kind,
                        input logic [1:0] src, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_dest_id = id; in_mode = mode; in_kind = kind; in_src = src;
        while (!in_ready) @(negedge clk);
        expq.push_back(model(id, mode, kind, src));
        tagq.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a < AW'(N)) ldr_m[a] = d;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        check(reg_rd_data === exp, tag, 32'(reg_rd_data), 32'(exp));
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected output", 32'({out_bus_en, out_claim}), 32'(0));
            end else begin
                logic [N+1:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({out_bus_en, out_claim} === e, t, 32'({out_bus_en, out_claim}), 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) ldr_m[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
        check(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
        rd_check(AW'(0), 8'h00, "R1 ldr0");
        rd_check(AW'(N), 8'h00, "R1 status");

        for (int i = 0; i < N - 1; i++) wr(AW'(i), 8'(1 << i));
        wr(AW'(N - 1), 8'h81);
        rd_check(AW'(N - 1), 8'h81, "R4 ldr readback");

        send(phys_m[3], 1'b0, 2'd0, 2'd0, "R2 R6 phys io");
        send(phys_m[5], 1'b0, 2'd0, 2'd1, "R2 R7 phys bus0");
        send(phys_m[0], 1'b0, 2'd0, 2'd2, "R2 R7 phys bus1");
        send(8'hFF, 1'b0, 2'd0, 2'd1, "R3 phys all-ones");
        send(8'hFF, 1'b1, 2'd0, 2'd2, "R3 logic all-ones");
        send(8'h06, 1'b1, 2'd0, 2'd0, "R4 logic multi");
        send(8'h01, 1'b1, 2'd0, 2'd1, "R4 logic overlap");
        send(phys_m[6], 1'b0, 2'd1, 2'd2, "R8 redirect bus1");
        send(8'h40, 1'b1, 2'd1, 2'd1, "R8 redirect bus0");
        send(8'h00, 1'b0, 2'd2, 2'd2, "R5 bcast kind");
        send(8'h00, 1'b1, 2'd2, 2'd0, "R5 R6 bcast io");

        // R10 no-target
        rd_check(AW'(N), 8'h00, "R10 status clear before");
        send(8'h01, 1'b0, 2'd0, 2'd0, "R10 no-target phys");
        rd_check(AW'(N), 8'h01, "R10 status set");
        send(phys_m[1], 1'b0, 2'd0, 2'd0, "R10 targeted after");
        rd_check(AW'(N), 8'h01, "R10 status sticky");
        wr(AW'(N), 8'h02);
        rd_check(AW'(N), 8'h01, "R12 format bit ignored");
        wr(AW'(N), 8'h01);
        rd_check(AW'(N), 8'h00, "R10 w1c");

        // R11 write on same edge as a message
        fork
            wr(AW'(2), 8'h00);
            send(8'h04, 1'b1, 2'd0, 2'd0, "R11 old ldr used");
        join
        send(8'h04, 1'b1, 2'd0, 2'd0, "R11 new ldr used");
        rd_check(AW'(N), 8'h01, "R11 R10 no-target after write");

        // R9 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        send(phys_m[4], 1'b0, 2'd0, 2'd1, "R9 held result");
        fork
            send(phys_m[2], 1'b0, 2'd1, 2'd0, "R9 second message");
            begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(in_ready === 1'b0, "R9 in_ready low", 32'(in_ready), 0);
                    check(out_valid === 1'b1 && {out_bus_en, out_claim} === expq[0],
                          "R9 hold", 32'({out_bus_en, out_claim}), 32'(expq[0]));
                end
                @(posedge clk);
                #1 out_ready = 1'b1;
            end
        join

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R9 all results seen", 32'(expq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule